// File: doc/BRIEF.md
# Strobed Parallel Port with Address Decode

This block sits on a byte-wide I/O bus and serves one block of eight consecutive port addresses. The lowest address of the block is a parallel digital port. Writes to it land in an 8-bit output register. Reads from it pass the external input byte onto the read-data bus. The other seven addresses belong to analog channels, and the block only flags them for an analog sequencer through one select line per channel.

The block's position in the port space is set by a strap input. The strap carries the upper address bits and is compared with the bus address. The usual strap value is 5'b00011, which maps the block to ports 0x18 through 0x1F.

A bus cycle opens on a clock edge where the sync qualifier is high. At that edge the address and the direction status are captured. The cycle stays open while the captured direction status stays asserted. The write and read strobes are active low and rest high. Each strobe goes low for the span of its transfer, and its rising edge back to idle marks a finished transfer.

Top module: `pio_block`

## Requirements
- R1: An access is decoded only when busAddr[7:3] equals blockBase. For any other address, both strobes stay 1, dataInEn stays 0, dataIn stays 0 and analogSel stays 0.
- R2: A cycle is captured only at a clock edge where syncStat is 1 and exactly one of outStat and inStat is 1. Status asserted without sync, or both statuses asserted at sync, starts no access.
- R3: During a captured write cycle to offset 0 (busAddr[2:0]==0), outStrobeN is 0 exactly while wrPulse is 1. At each clock edge inside that window, portOut takes dataOut.
- R4: portOut holds its value between digital writes. Writes to offsets 1 to 7 and all reads leave it unchanged.
- R5: During a captured read cycle to offset 0, dataInEn is 1, inStrobeN is 0 and dataIn equals extIn for as long as inStat stays 1.
- R6: During a captured access to offset k, where k is 1 to 7, analogSel is one-hot with only bit k-1 set. analogWrite is 1 for writes and 0 for reads. Neither digital strobe moves.
- R7: Reset (rst_n low) clears portOut to 0, sets both strobes to 1, and drives dataInEn, dataIn and analogSel to 0.
- R8: When the captured direction status falls, the cycle closes. Both strobes return to 1, and analogSel and dataInEn return to 0.
- R9: When dataInEn is 0, dataIn is driven to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blockBase | input | 5 | Strap holding the upper address bits of the port block |
| busAddr | input | 8 | Port address |
| syncStat | input | 1 | Cycle-start qualifier |
| outStat | input | 1 | Output-direction status |
| inStat | input | 1 | Input-direction status |
| wrPulse | input | 1 | Write timing pulse |
| dataOut | input | 8 | Write-data bus |
| extIn | input | 8 | External parallel input byte |
| portOut | output | 8 | Latched parallel output byte |
| outStrobeN | output | 1 | Output strobe, idle 1 |
| inStrobeN | output | 1 | Input strobe, idle 1 |
| dataIn | output | 8 | Read-data bus value |
| dataInEn | output | 1 | Enable for the read-data bus drivers |
| analogSel | output | 7 | One-hot analog channel select |
| analogWrite | output | 1 | Direction of the current analog access |

## Verification
The hardest cases to reach are the ones where status lines move without a proper sync capture. Examples are a write pulse under an asserted output status with no sync edge, and a sync edge with both directions asserted. In both cases nothing may leak through. The bench sets these up by hand between the normal cycles. It also sweeps every one of the 256 addresses in both directions under several strap values, so every offset and every near-miss base is decoded. Because the output register is carried across the whole sweep, writes to analog offsets and accesses that miss the block show up as a corrupted held value.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_WR   = 2'd1,
    DIR_RD   = 2'd2
  } accDir_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchEn;  // capture write data into the output register
    logic driveEn;  // put the external byte on the read bus
  } pioStrobes_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 8,
  localparam int OFF_W    = $clog2(NUM_PORTS),
  localparam int BASE_W   = ADDR_W - OFF_W,
  localparam int NUM_ANA  = NUM_PORTS - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BASE_W-1:0]  blockBase,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               syncStat,
  input  logic               outStat,
  input  logic               inStat,
  input  logic               wrPulse,
  output pioStrobes_t        strobes,
  output logic [NUM_ANA-1:0] anaSel,
  output logic               anaWrite
);

  accDir_t           cycDir;
  logic [OFF_W-1:0]  cycOff;
  logic              baseMatch;
  logic              oneDir;
  logic              wrLive;
  logic              rdLive;
  logic              digSel;

  assign baseMatch = (busAddr[ADDR_W-1:OFF_W] == blockBase);
  assign oneDir    = outStat ^ inStat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycDir <= DIR_NONE;
      cycOff <= '0;
    end else if (syncStat) begin
      cycOff <= busAddr[OFF_W-1:0];
      if (baseMatch && oneDir)
        cycDir <= outStat ? DIR_WR : DIR_RD;
      else
        cycDir <= DIR_NONE;
    end else if ((cycDir == DIR_WR && !outStat) ||
                 (cycDir == DIR_RD && !inStat)) begin
      cycDir <= DIR_NONE;
    end
  end

  assign wrLive = (cycDir == DIR_WR) && outStat;
  assign rdLive = (cycDir == DIR_RD) && inStat;
  assign digSel = (cycOff == '0);

  assign strobes.latchEn = wrLive && digSel && wrPulse;
  assign strobes.driveEn = rdLive && digSel;

  for (genvar k = 1; k < NUM_PORTS; k++) begin : g_anaSel
    assign anaSel[k-1] = (wrLive || rdLive) && (cycOff == OFF_W'(k));
  end

  assign anaWrite = wrLive && !digSel;

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pioStrobes_t       strobes,
  input  logic [DATA_W-1:0] dataOut,
  input  logic [DATA_W-1:0] extIn,
  output logic [DATA_W-1:0] portOut,
  output logic [DATA_W-1:0] dataIn,
  output logic              dataInEn,
  output logic              outStrobeN,
  output logic              inStrobeN
);

  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      outReg <= '0;
    else if (strobes.latchEn)
      outReg <= dataOut;
  end

  assign portOut    = outReg;
  assign dataInEn   = strobes.driveEn;
  assign dataIn     = strobes.driveEn ? extIn : '0;
  assign outStrobeN = !strobes.latchEn;
  assign inStrobeN  = !strobes.driveEn;

endmodule

// File: rtl/pio_block.sv
module pio_block
  import pio_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 8,
  localparam int OFF_W    = $clog2(NUM_PORTS),
  localparam int BASE_W   = ADDR_W - OFF_W,
  localparam int NUM_ANA  = NUM_PORTS - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BASE_W-1:0]  blockBase,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               syncStat,
  input  logic               outStat,
  input  logic               inStat,
  input  logic               wrPulse,
  input  logic [DATA_W-1:0]  dataOut,
  input  logic [DATA_W-1:0]  extIn,
  output logic [DATA_W-1:0]  portOut,
  output logic               outStrobeN,
  output logic               inStrobeN,
  output logic [DATA_W-1:0]  dataIn,
  output logic               dataInEn,
  output logic [NUM_ANA-1:0] analogSel,
  output logic               analogWrite
);

  pioStrobes_t strobes;

  pio_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .blockBase (blockBase),
    .busAddr   (busAddr),
    .syncStat  (syncStat),
    .outStat   (outStat),
    .inStat    (inStat),
    .wrPulse   (wrPulse),
    .strobes   (strobes),
    .anaSel    (analogSel),
    .anaWrite  (analogWrite)
  );

  pio_datapath #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .dataOut    (dataOut),
    .extIn      (extIn),
    .portOut    (portOut),
    .dataIn     (dataIn),
    .dataInEn   (dataInEn),
    .outStrobeN (outStrobeN),
    .inStrobeN  (inStrobeN)
  );

endmodule

// File: rtl/pio_block_chk.sv
module pio_block_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_ANA = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrPulse,
  input logic [DATA_W-1:0]  extIn,
  input logic [DATA_W-1:0]  portOut,
  input logic               outStrobeN,
  input logic               inStrobeN,
  input logic [DATA_W-1:0]  dataIn,
  input logic               dataInEn,
  input logic [NUM_ANA-1:0] analogSel
);

  // R3
  out_strobe_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outStrobeN |-> wrPulse);

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outStrobeN |=> $stable(portOut));

  // R5
  read_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataInEn |-> (dataIn == extIn && !inStrobeN));

  // R9
  read_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dataInEn |-> (dataIn == '0 && inStrobeN));

  // R6
  analog_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(analogSel));

  // R6
  analog_no_digital_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (analogSel != '0) |-> (outStrobeN && inStrobeN));

  // R2
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outStrobeN || inStrobeN);

endmodule

bind pio_block pio_block_chk #(
  .DATA_W  (DATA_W),
  .NUM_ANA (NUM_ANA)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrPulse    (wrPulse),
  .extIn      (extIn),
  .portOut    (portOut),
  .outStrobeN (outStrobeN),
  .inStrobeN  (inStrobeN),
  .dataIn     (dataIn),
  .dataInEn   (dataInEn),
  .analogSel  (analogSel)
);

// File: tb/pio_block_bench.sv
module pio_block_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] blockBase = 5'b00011;
  logic [7:0] busAddr = '0;
  logic       syncStat = 1'b0;
  logic       outStat = 1'b0;
  logic       inStat = 1'b0;
  logic       wrPulse = 1'b0;
  logic [7:0] dataOut = '0;
  logic [7:0] extIn = '0;
  logic [7:0] portOut;
  logic       outStrobeN;
  logic       inStrobeN;
  logic [7:0] dataIn;
  logic       dataInEn;
  logic [6:0] analogSel;
  logic       analogWrite;

  int total = 0;
  int bad = 0;
  logic [7:0] expLatch = '0;

  always #2.5 clk = ~clk;

  pio_block u_pio_block (
    .clk(clk), .rst_n(rst_n), .blockBase(blockBase), .busAddr(busAddr),
    .syncStat(syncStat), .outStat(outStat), .inStat(inStat), .wrPulse(wrPulse),
    .dataOut(dataOut), .extIn(extIn), .portOut(portOut), .outStrobeN(outStrobeN),
    .inStrobeN(inStrobeN), .dataIn(dataIn), .dataInEn(dataInEn),
    .analogSel(analogSel), .analogWrite(analogWrite)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, {15'd0, outStrobeN}, 16'd1);
    check(req, {15'd0, inStrobeN}, 16'd1);
    check(req, {15'd0, dataInEn}, 16'd0);
    check(req, {8'd0, dataIn}, 16'd0);
    check(req, {9'd0, analogSel}, 16'd0);
    check(req, {8'd0, portOut}, {8'd0, expLatch});
  endtask

  task automatic access(input bit isWr, input logic [7:0] a, input logic [7:0] d);
    bit hit;
    bit dig;
    string tag;
    hit = (a[7:3] == blockBase);
    dig = (a[2:0] == 3'd0);
    tag = !hit ? "R1" : (dig ? (isWr ? "R3" : "R5") : "R6");
    @(negedge clk);
    busAddr = a; syncStat = 1'b1; outStat = isWr; inStat = !isWr;
    dataOut = d; extIn = ~d;
    @(negedge clk);
    syncStat = 1'b0;
    wrPulse = isWr;
    #1;
    check(tag, {15'd0, outStrobeN}, {15'd0, !(isWr && hit && dig)});
    check(tag, {15'd0, inStrobeN}, {15'd0, !(!isWr && hit && dig)});
    check(tag, {15'd0, dataInEn}, {15'd0, (!isWr && hit && dig)});
    check(tag, {8'd0, dataIn}, (!isWr && hit && dig) ? {8'd0, ~d} : 16'd0);
    check(tag, {9'd0, analogSel}, (hit && !dig) ? 16'(1 << (a[2:0] - 3'd1)) : 16'd0);
    check(tag, {15'd0, analogWrite}, {15'd0, (isWr && hit && !dig)});
    @(negedge clk);
    wrPulse = 1'b0;
    if (isWr && hit && dig) expLatch = d;
    #1;
    check("R4", {8'd0, portOut}, {8'd0, expLatch});
    check("R3", {15'd0, outStrobeN}, 16'd1);
    @(negedge clk);
    outStat = 1'b0; inStat = 1'b0;
    #1;
    checkIdle("R8");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] bases [4];
    bases[0] = 5'b00011; bases[1] = 5'b00000; bases[2] = 5'b11111; bases[3] = 5'b10101;
    #1;
    checkIdle("R7");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checkIdle("R7");

    for (int b = 0; b < 4; b++) begin
      blockBase = bases[b];
      for (int a = 0; a < 256; a++) begin
        access(1'b1, 8'(a), 8'(a * 37 + b * 11 + 1));
        access(1'b0, 8'(a), 8'(a * 53 + 5));
      end
    end

    // R2: status and write pulse without sync
    blockBase = 5'b00011;
    @(negedge clk);
    busAddr = 8'h18; outStat = 1'b1; dataOut = 8'hA5; wrPulse = 1'b1;
    #1;
    check("R2", {15'd0, outStrobeN}, 16'd1);
    @(negedge clk);
    #1;
    check("R2", {8'd0, portOut}, {8'd0, expLatch});
    wrPulse = 1'b0; outStat = 1'b0;

    // R2: both directions at sync
    @(negedge clk);
    busAddr = 8'h18; syncStat = 1'b1; outStat = 1'b1; inStat = 1'b1; extIn = 8'h3C;
    @(negedge clk);
    syncStat = 1'b0; wrPulse = 1'b1;
    #1;
    check("R2", {15'd0, outStrobeN}, 16'd1);
    check("R2", {15'd0, inStrobeN}, 16'd1);
    check("R2", {15'd0, dataInEn}, 16'd0);
    @(negedge clk);
    wrPulse = 1'b0; outStat = 1'b0; inStat = 1'b0;
    #1;
    check("R2", {8'd0, portOut}, {8'd0, expLatch});

    // R7: reset after a nonzero write
    access(1'b1, 8'h18, 8'hC3);
    check("R7", {8'd0, portOut}, 16'h00C3);
    @(negedge clk);
    rst_n = 1'b0;
    expLatch = '0;
    #1;
    checkIdle("R7");
    @(negedge clk);
    rst_n = 1'b1;

    // R9: the read bus stays zero outside reads
    #1;
    check("R9", {8'd0, dataIn}, 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule